// File: doc/BRIEF.md
# SPI Flash Command Protection Gate

This block sits behind the serial command decoder of an SPI flash slave. For each decoded instruction it decides whether the instruction may run. It keeps the protection-related status bits and a deep power-down flag. The decoder hands it one opcode strobe per instruction, together with the target address and, for a status write, the new status byte. The gate also samples the level of the write-protect pin.

One cycle later the gate answers with a single response carrying an accept flag. On the same edge it updates its status bits. When the instruction is a signature read, it also returns an 8-bit electronic signature. The memory array and the program and erase timing are outside the block, and so are the serial shifter and non-volatile storage. Downstream logic starts an array operation only when the gate accepts it.

The gate enforces four kinds of protection:
- A hardware lock formed by the status-write-disable bit together with the pin.
- The write-enable latch.
- Address checking against the block-protect field.
- Instruction filtering while the device is in deep power-down.

Top module: `flash_cmd_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status byte becomes 0, `deep_pd` becomes 0, and `rsp_valid` and `sig_valid` become 0.
- R2: Each cycle with `cmd_valid` high produces exactly one cycle of `rsp_valid` on the next cycle, with `rsp_accept` giving the verdict. The status byte is laid out as follows: bit 7 holds the status-write-disable bit, bits 5:2 hold the block-protect field, and bit 1 holds the write-enable latch. Bits 6 and 0 read 0.
- R3: Write-enable (06h) outside deep power-down is accepted and sets the write-enable latch.
- R4: The hardware lock is active exactly when status bit 7 is 1 and `wp_n` is 0. While it is active, a status write (01h) is rejected and bits 7 and 5:2 keep their values.
- R5: When the hardware lock is not active and the write-enable latch is set, a status write is accepted. It loads bit 7 from `cmd_wdata[7]` and the block-protect field from `cmd_wdata[5:2]`. A status write with the latch clear is rejected.
- R6: Status write, page program (02h), sector erase (20h), block erase (D8h) and chip erase (C7h) clear the write-enable latch whether they are accepted or rejected. Each of them is rejected when the latch is clear.
- R7: Page program, sector erase and block erase are rejected when the target block is protected. The target block is the top 4 address bits, giving 16 blocks. A block-protect value n from 1 to 4 protects the blocks numbered 16-2^(n-1) and above. Values 5 to 15 protect all blocks, and 0 protects none.
- R8: Chip erase is accepted only when the block-protect field is 0.
- R9: Deep power-down (B9h) is accepted and sets `deep_pd`.
- R10: While `deep_pd` is 1, every opcode except ABh is rejected. The status byte and `deep_pd` stay unchanged.
- R11: Opcode ABh is always accepted and clears `deep_pd`. On the response cycle `sig_valid` is 1 and `sig_data` equals the signature parameter (default 8'h13).
- R12: Any opcode not listed above is rejected and leaves the status byte and `deep_pd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Decoded instruction strobe, one cycle per instruction |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | ADDR_W | Target byte address for program and erase |
| cmd_wdata | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| rsp_valid | output | 1 | Verdict strobe, one cycle after `cmd_valid` |
| rsp_accept | output | 1 | 1 when the instruction may run |
| stat_q | output | 8 | Status byte |
| deep_pd | output | 1 | Deep power-down state |
| sig_valid | output | 1 | Signature byte valid |
| sig_data | output | 8 | Electronic signature |

## Verification
Every result of this block is registered once: the verdict, the new status byte, the power-down flag and the signature all change on the first clock edge after the strobe. The bench drives each instruction on a falling edge. It samples all outputs at the next falling edge, which lies half a period after the edge that updates them, so no check races the registers. The bench follows the status bits and power-down state with its own arithmetic model, and it predicts each verdict before it issues the instruction.

// File: rtl/flash_gate_pkg.sv
// Shared opcodes, status fields and action types for the command gate.
// Assumes 8-bit opcodes arriving already decoded from the serial shifter.
package flash_gate_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_PP   = 8'h02;
    localparam logic [7:0] OP_SE   = 8'h20;
    localparam logic [7:0] OP_BE   = 8'hD8;
    localparam logic [7:0] OP_CE   = 8'hC7;
    localparam logic [7:0] OP_DP   = 8'hB9;
    localparam logic [7:0] OP_RES  = 8'hAB;

    typedef enum logic [2:0] {
        K_WREN, K_WRSR, K_PROG, K_CHIP, K_SLEEP, K_WAKE, K_OTHER
    } op_kind_t;

    typedef struct packed {
        logic       srwd;
        logic [3:0] bp;
        logic       wel;
    } stat_t;

    typedef struct packed {
        logic accept;
        logic set_wel;
        logic clr_wel;
        logic load_sr;
        logic enter_pd;
        logic leave_pd;
        logic give_sig;
    } act_t;
endpackage

// File: rtl/fg_op_class.sv
// Maps an opcode byte onto the instruction class used by the decision logic.
// Assumes opcode values from flash_gate_pkg; unknown bytes map to K_OTHER.
module fg_op_class
    import flash_gate_pkg::*;
(
    input  logic [7:0] op,
    output op_kind_t   kind
);
    // classify the opcode
    always_comb begin
        unique case (op)
            OP_WREN:             kind = K_WREN;
            OP_WRSR:             kind = K_WRSR;
            OP_PP, OP_SE, OP_BE: kind = K_PROG;
            OP_CE:               kind = K_CHIP;
            OP_DP:               kind = K_SLEEP;
            OP_RES:              kind = K_WAKE;
            default:             kind = K_OTHER;
        endcase
    end
endmodule

// File: rtl/fg_blk_prot.sv
// Decides whether a target address lies in the area locked by the
// block-protect field. Value n>0 locks the top 2^(n-1) blocks, capped at all.
// Assumes the block index is the top BLK_LOG address bits.
module fg_blk_prot #(
    parameter int ADDR_W  = 16,
    parameter int BLK_LOG = 4
) (
    input  logic [3:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned NBLK = 1 << BLK_LOG;

    logic [BLK_LOG-1:0] blk;
    logic [31:0]        shift_amt;
    logic [31:0]        first_blk;

    assign blk = addr[ADDR_W-1 -: BLK_LOG];

    // compute lowest locked block and compare
    always_comb begin
        shift_amt = 32'(bp) - 32'd1;
        first_blk = 32'(NBLK) - (32'd1 << shift_amt[4:0]);
        if (bp == 4'd0)
            hit = 1'b0;
        else if (shift_amt >= 32'(BLK_LOG))
            hit = 1'b1;
        else
            hit = 32'(blk) >= first_blk;
    end

    // R7
    always_comb begin
        blk_zero_open_chk: assert (!(bp == 4'd0 && hit));
    end
endmodule

// File: rtl/fg_decide.sv
// Combinational verdict for one instruction: applies power-down filtering,
// the hardware lock (SRWD with WP low), the write-enable latch and the
// block-protect check. Assumes prot_hit is valid for the current address.
module fg_decide
    import flash_gate_pkg::*;
(
    input  op_kind_t kind,
    input  stat_t    st,
    input  logic     wp_n,
    input  logic     pd,
    input  logic     prot_hit,
    output act_t     act
);
    logic hw_lock;

    assign hw_lock = st.srwd & ~wp_n;

    // select the action set for this instruction
    always_comb begin
        act = '0;
        if (pd) begin
            if (kind == K_WAKE) begin
                act.accept   = 1'b1;
                act.leave_pd = 1'b1;
                act.give_sig = 1'b1;
            end
        end else begin
            unique case (kind)
                K_WREN: begin
                    act.accept  = 1'b1;
                    act.set_wel = 1'b1;
                end
                K_WRSR: begin
                    act.clr_wel = 1'b1;
                    act.accept  = st.wel & ~hw_lock;
                    act.load_sr = st.wel & ~hw_lock;
                end
                K_PROG: begin
                    act.clr_wel = 1'b1;
                    act.accept  = st.wel & ~prot_hit;
                end
                K_CHIP: begin
                    act.clr_wel = 1'b1;
                    act.accept  = st.wel & (st.bp == 4'd0);
                end
                K_SLEEP: begin
                    act.accept   = 1'b1;
                    act.enter_pd = 1'b1;
                end
                K_WAKE: begin
                    act.accept   = 1'b1;
                    act.give_sig = 1'b1;
                end
                default: act = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_gate.sv
// Top of the command protection gate. Registers the verdict, the status
// bits and the power-down flag one cycle after each instruction strobe.
// Assumes at most one strobe per cycle; reset is synchronous, active low.
module flash_cmd_gate
    import flash_gate_pkg::*;
#(
    parameter int         ADDR_W   = 16,
    parameter int         BLK_LOG  = 4,
    parameter logic [7:0] SIG_BYTE = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_wdata,
    input  logic              wp_n,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic [7:0]        stat_q,
    output logic              deep_pd,
    output logic              sig_valid,
    output logic [7:0]        sig_data
);
    op_kind_t kind;
    stat_t    st;
    logic     prot_hit;
    act_t     act;

    fg_op_class u_class (
        .op   (cmd_op),
        .kind (kind)
    );

    fg_blk_prot #(.ADDR_W(ADDR_W), .BLK_LOG(BLK_LOG)) u_prot (
        .bp   (st.bp),
        .addr (cmd_addr),
        .hit  (prot_hit)
    );

    fg_decide u_decide (
        .kind     (kind),
        .st       (st),
        .wp_n     (wp_n),
        .pd       (deep_pd),
        .prot_hit (prot_hit),
        .act      (act)
    );

    // status bits and power-down state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= '0;
            deep_pd <= 1'b0;
        end else if (cmd_valid) begin
            if (act.load_sr) begin
                st.srwd <= cmd_wdata[7];
                st.bp   <= cmd_wdata[5:2];
            end
            if (act.set_wel)
                st.wel <= 1'b1;
            else if (act.clr_wel)
                st.wel <= 1'b0;
            if (act.enter_pd)
                deep_pd <= 1'b1;
            else if (act.leave_pd)
                deep_pd <= 1'b0;
        end
    end

    // verdict and signature response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_accept <= 1'b0;
            sig_valid  <= 1'b0;
            sig_data   <= 8'h00;
        end else begin
            rsp_valid  <= cmd_valid;
            rsp_accept <= cmd_valid & act.accept;
            sig_valid  <= cmd_valid & act.give_sig;
            sig_data   <= (cmd_valid & act.give_sig) ? SIG_BYTE : 8'h00;
        end
    end

    assign stat_q = {st.srwd, 1'b0, st.bp, st.wel, 1'b0};

    // R2
    resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    // R4
    hw_lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRSR && stat_q[7] && !wp_n)
        |=> (!rsp_accept && $stable(stat_q[7:2])));

    // R6
    wel_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !deep_pd && (cmd_op == OP_WRSR || cmd_op == OP_PP ||
         cmd_op == OP_SE || cmd_op == OP_BE || cmd_op == OP_CE))
        |=> !stat_q[1]);

    // R8
    chip_erase_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_CE && stat_q[5:2] != 4'd0) |=> !rsp_accept);

    // R10
    sleep_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && deep_pd && cmd_op != OP_RES)
        |=> (!rsp_accept && deep_pd && $stable(stat_q)));

    // R11
    sig_with_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> (rsp_accept && !deep_pd && sig_data == SIG_BYTE));
endmodule

// File: tb/flash_cmd_gate_tb.sv
`timescale 1ns/1ps
module flash_cmd_gate_tb;
    localparam int         ADDR_W = 16;
    localparam logic [7:0] SIG    = 8'h13;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic [7:0]        cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_wdata;
    logic              wp_n;
    logic              rsp_valid, rsp_accept, deep_pd, sig_valid;
    logic [7:0]        stat_q, sig_data;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  m_srwd = 0;
    bit  m_wel  = 0;
    bit  m_pd   = 0;
    logic [3:0] m_bp = '0;

    always #4 clk = ~clk;

    flash_cmd_gate #(.ADDR_W(ADDR_W), .BLK_LOG(4), .SIG_BYTE(SIG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .stat_q(stat_q),
        .deep_pd(deep_pd), .sig_valid(sig_valid), .sig_data(sig_data));

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit locked(input logic [3:0] bp, input int blk);
        if (bp == 0) return 0;
        if (bp >= 5) return 1;
        return blk >= (16 - (1 << (bp - 1)));
    endfunction

    // Predict, issue one instruction, then check all outputs a cycle later.
    task automatic issue(input logic [7:0] op, input logic [ADDR_W-1:0] addr,
                         input logic [7:0] wd, input string req);
        bit exp_acc = 0;
        bit exp_sig = 0;
        bit wr_type = (op == 8'h01 || op == 8'h02 || op == 8'h20 ||
                       op == 8'hD8 || op == 8'hC7);
        if (m_pd) begin
            if (op == 8'hAB) begin exp_acc = 1; exp_sig = 1; m_pd = 0; end
        end else begin
            case (op)
                8'h06: begin exp_acc = 1; m_wel = 1; end
                8'h01: begin
                    exp_acc = m_wel && !(m_srwd && !wp_n);
                    if (exp_acc) begin m_srwd = wd[7]; m_bp = wd[5:2]; end
                end
                8'h02, 8'h20, 8'hD8:
                    exp_acc = m_wel && !locked(m_bp, int'(addr[15:12]));
                8'hC7: exp_acc = m_wel && (m_bp == 0);
                8'hB9: begin exp_acc = 1; m_pd = 1; end
                8'hAB: begin exp_acc = 1; exp_sig = 1; end
                default: exp_acc = 0;
            endcase
            if (wr_type) m_wel = 0;
        end
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 0;
        check("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "rsp_accept", 32'(rsp_accept), 32'(exp_acc));
        check(req, "stat_q", 32'(stat_q),
              32'({m_srwd, 1'b0, m_bp, m_wel, 1'b0}));
        check(req, "deep_pd", 32'(deep_pd), 32'(m_pd));
        check("R11", "sig_valid", 32'(sig_valid), 32'(exp_sig));
        if (exp_sig) check("R11", "sig_data", 32'(sig_data), 32'(SIG));
    endtask

    task automatic set_status(input bit srwd, input logic [3:0] bp);
        logic saved = wp_n;
        wp_n = 1;
        issue(8'h06, '0, 8'h00, "R3");
        issue(8'h01, '0, {srwd, 1'b0, bp, 2'b00}, "R5");
        wp_n = saved;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_wdata = 0; wp_n = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "stat_q", 32'(stat_q), 32'd0);
        check("R1", "deep_pd", 32'(deep_pd), 32'd0);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1", "sig_valid", 32'(sig_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        check("R2", "idle rsp_valid", 32'(rsp_valid), 32'd0);

        // R6: writes without the latch are rejected
        issue(8'h02, 16'h0000, 8'h00, "R6");
        issue(8'h01, 16'h0000, 8'hBC, "R6");
        issue(8'hC7, 16'h0000, 8'h00, "R6");
        issue(8'h06, 16'h0000, 8'h00, "R3");

        // R7 and R8: sweep every protect value, block and program/erase kind
        for (int bp = 0; bp < 16; bp++) begin
            set_status(0, 4'(bp));
            for (int blk = 0; blk < 16; blk++) begin
                issue(8'h06, '0, 8'h00, "R3");
                issue(8'h02, 16'(blk << 12) | 16'h0123, 8'h00, "R7");
                issue(8'h06, '0, 8'h00, "R3");
                issue(8'h20, 16'(blk << 12) | 16'h0FFF, 8'h00, "R7");
                issue(8'h06, '0, 8'h00, "R3");
                issue(8'hD8, 16'(blk << 12), 8'h00, "R7");
            end
            issue(8'h06, '0, 8'h00, "R3");
            issue(8'hC7, '0, 8'h00, "R8");
        end

        // R4 and R5: every SRWD and pin combination against a status write
        for (int s = 0; s < 2; s++) begin
            for (int w = 0; w < 2; w++) begin
                set_status(s[0], 4'h3);
                wp_n = w[0];
                issue(8'h06, '0, 8'h00, "R3");
                issue(8'h01, '0, {s[0], 1'b0, 4'hA, 2'b00}, "R4");
                wp_n = 1;
            end
        end
        set_status(0, 4'h0);

        // R12: unknown opcode changes nothing
        issue(8'h06, '0, 8'h00, "R3");
        issue(8'h55, '0, 8'h00, "R12");
        issue(8'h03, '0, 8'h00, "R12");

        // R11 outside power-down
        issue(8'hAB, '0, 8'h00, "R11");

        // R9, R10, R11: deep power-down filtering and release
        issue(8'h06, '0, 8'h00, "R3");
        issue(8'hB9, '0, 8'h00, "R9");
        issue(8'h06, '0, 8'h00, "R10");
        issue(8'h01, '0, 8'hFC, "R10");
        issue(8'h02, '0, 8'h00, "R10");
        issue(8'h20, '0, 8'h00, "R10");
        issue(8'hD8, '0, 8'h00, "R10");
        issue(8'hC7, '0, 8'h00, "R10");
        issue(8'hB9, '0, 8'h00, "R10");
        issue(8'h9F, '0, 8'h00, "R10");
        issue(8'hAB, '0, 8'h00, "R11");
        issue(8'h06, '0, 8'h00, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule